// File: doc/BRIEF.md
# Circular Frame Buffer Address Generator

This block produces the memory addresses that a display scanout engine needs when the frame buffer is used as a ring for hardware scrolling. It holds a window base address and a current start address inside that window. The buffer size and the memory type come in as static configuration pins. A command port moves the start: by a signed byte offset that wraps inside the window, back to the base, to a saved address, or along with a moved base so that the scroll displacement is kept.

The scanout DMA registers (init, start, end) and the frame-length value are shadowed. They take new values only on a vertical-sync pulse, so a scroll that is issued in mid-frame never tears the picture. The programmed end is the start plus the buffer size, less one transfer. A transfer is 16 bytes for DRAM-backed memory and the buffer size divided by 1024 for VRAM-backed memory. A fetch-address stream restarts at the start on each vertical sync. It advances by one transfer per accepted request and wraps from the top of the window to its base.

The command port is a valid/ready stream. Ready is low during reset and constantly high after it, so a command is taken in the cycle it is offered. The fetch port is a valid/ready stream that the consumer back-pressures: while ready is low the address holds. Vertical sync, the frame-length counts, the buffer size and the memory type are plain control pins.

Top module: `fbscan_addr_gen`

## Requirements
- R1: While rst_n is low, cur_start, prev_start, dma_init, dma_start, dma_end and frame_size read RST_BASE, RST_BASE, 0, 0, 0 and 0, fetch_valid is 0 and cmd_ready is 0.
- R2: Opcode 0 (scroll) sets the start to start plus the sign-extended offset in cmd_arg. If the sum is at or above base plus buf_size, buf_size is subtracted. If it is below base, buf_size is added. Offsets have a magnitude below buf_size.
- R3: Every address taken from cmd_arg (scroll offset, restore address, new base) first has its low bits cleared down to a multiple of the transfer size. A negative offset therefore rounds toward the lower address.
- R4: The transfer size is 16 bytes when mem_vram is 0 and buf_size/1024 bytes when mem_vram is 1. buf_size is a power of two of at least 16384.
- R5: Opcode 1 (home) sets the start to the base and places the start that it replaced on prev_start. No other command changes prev_start.
- R6: Opcode 2 (restore) sets the start to the rounded cmd_arg, which the caller keeps inside the window.
- R7: Opcode 3 (rebase) sets the base to the rounded cmd_arg and moves the start to new base plus (old start minus old base).
- R8: On a cycle with vsync high, dma_init and dma_start take the start and dma_end takes start + buf_size - transfer size, all visible after that edge.
- R9: dma_init, dma_start, dma_end and frame_size do not change in a cycle without vsync.
- R10: On vsync, frame_size takes v_total + v_sync + v_bstart + v_bend - 1.
- R11: fetch_valid rises at the first vsync and stays high. Each vsync reloads fetch_addr with the start. An accepted fetch (valid and ready, no vsync) adds one transfer, and an address reaching base + buf_size wraps by subtracting buf_size. With ready low the address holds.
- R12: cmd_ready is high in every cycle after reset. A command offered with cmd_valid low has no effect. When a command and vsync share a cycle, the shadow and fetch registers take the start from before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | 0 scroll, 1 home, 2 restore, 3 rebase |
| cmd_arg | input | AW | Signed offset or address for the command |
| buf_size | input | AW | Window size in bytes, static |
| mem_vram | input | 1 | 1 selects VRAM transfer sizing, 0 DRAM |
| vsync | input | 1 | One-cycle vertical-sync pulse |
| v_total | input | FW | Vertical total count |
| v_sync | input | FW | Vertical sync width count |
| v_bstart | input | FW | Border start count |
| v_bend | input | FW | Border end count |
| cur_start | output | AW | Live start address |
| prev_start | output | AW | Start replaced by the last home command |
| dma_init | output | AW | Shadowed DMA init address |
| dma_start | output | AW | Shadowed DMA start address |
| dma_end | output | AW | Shadowed DMA end address |
| frame_size | output | FW | Shadowed frame length |
| fetch_valid | output | 1 | Fetch address is valid |
| fetch_ready | input | 1 | Consumer takes the fetch address |
| fetch_addr | output | AW | Current fetch address |

## Verification
A corrupted start register shows on cur_start one cycle after the command and reaches the DMA shadow values at the next vsync edge. A bad wrap compare shows as a fetch address that leaves the window at the first request that crosses the buffer top. A wrong transfer size shows at once in dma_end after a vsync and in the step between successive fetch addresses. A shadow register that loads outside vsync changes dma outputs in a cycle where they must hold, and that is seen on the next edge.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;
  typedef enum logic [1:0] {
    OP_SCROLL  = 2'd0,
    OP_HOME    = 2'd1,
    OP_RESTORE = 2'd2,
    OP_REBASE  = 2'd3
  } scan_op_e;
endpackage

// File: rtl/fbscan_xfer.sv
module fbscan_xfer #(
  parameter int AW = 32,
  parameter int DRAM_XFER = 16,
  parameter int VRAM_SHIFT = 10
) (
  input  logic [AW-1:0] buf_size,
  input  logic          mem_vram,
  output logic [AW-1:0] xfer_bytes,
  output logic [AW-1:0] xfer_mask
);
  always_comb begin
    if (mem_vram) xfer_bytes = buf_size >> VRAM_SHIFT;
    else          xfer_bytes = AW'(DRAM_XFER);
    xfer_mask = xfer_bytes - AW'(1);
  end
endmodule

// File: rtl/fbscan_window.sv
module fbscan_window
  import fbscan_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] RST_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_fire,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_arg,
  input  logic [AW-1:0] buf_size,
  input  logic [AW-1:0] xfer_mask,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] prev_q
);
  localparam int SW = AW + 2;

  logic [AW-1:0]        arg_al;
  logic signed [SW-1:0] sum_s, lo_s, hi_s, wrap_s;
  logic [AW-1:0]        scroll_res;
  logic [AW-1:0]        rebase_res;
  scan_op_e             op;

  always_comb begin
    op     = scan_op_e'(cmd_op);
    arg_al = cmd_arg & ~xfer_mask;
    sum_s  = $signed({2'b00, start_q}) + $signed({{2{arg_al[AW-1]}}, arg_al});
    lo_s   = $signed({2'b00, base_q});
    hi_s   = lo_s + $signed({2'b00, buf_size});
    if (sum_s >= hi_s)     wrap_s = sum_s - $signed({2'b00, buf_size});
    else if (sum_s < lo_s) wrap_s = sum_s + $signed({2'b00, buf_size});
    else                   wrap_s = sum_s;
    scroll_res = wrap_s[AW-1:0];
    rebase_res = start_q - base_q + arg_al;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= RST_BASE;
      start_q <= RST_BASE;
      prev_q  <= RST_BASE;
    end else if (cmd_fire) begin
      case (op)
        OP_SCROLL:  start_q <= scroll_res;
        OP_HOME: begin
          start_q <= base_q;
          prev_q  <= start_q;
        end
        OP_RESTORE: start_q <= arg_al;
        OP_REBASE: begin
          base_q  <= arg_al;
          start_q <= rebase_res;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fbscan_shadow.sv
module fbscan_shadow #(
  parameter int AW = 32,
  parameter int FW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vsync,
  input  logic [AW-1:0] start_q,
  input  logic [AW-1:0] buf_size,
  input  logic [AW-1:0] xfer_bytes,
  input  logic [FW-1:0] v_total,
  input  logic [FW-1:0] v_sync,
  input  logic [FW-1:0] v_bstart,
  input  logic [FW-1:0] v_bend,
  output logic [AW-1:0] dma_init,
  output logic [AW-1:0] dma_start,
  output logic [AW-1:0] dma_end,
  output logic [FW-1:0] frame_size
);
  logic [FW-1:0] fsum;
  logic [AW-1:0] end_val;

  always_comb begin
    fsum    = v_total + v_sync + v_bstart + v_bend - FW'(1);
    end_val = start_q + buf_size - xfer_bytes;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_init   <= '0;
      dma_start  <= '0;
      dma_end    <= '0;
      frame_size <= '0;
    end else if (vsync) begin
      dma_init   <= start_q;
      dma_start  <= start_q;
      dma_end    <= end_val;
      frame_size <= fsum;
    end
  end
endmodule

// File: rtl/fbscan_fetch.sv
module fbscan_fetch #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vsync,
  input  logic [AW-1:0] start_q,
  input  logic [AW-1:0] base_q,
  input  logic [AW-1:0] buf_size,
  input  logic [AW-1:0] xfer_bytes,
  input  logic          fetch_ready,
  output logic          fetch_valid,
  output logic [AW-1:0] fetch_addr
);
  logic [AW:0]   nxt, limit, nxt_w;
  logic [AW-1:0] step_addr;

  always_comb begin
    nxt   = {1'b0, fetch_addr} + {1'b0, xfer_bytes};
    limit = {1'b0, base_q} + {1'b0, buf_size};
    if (nxt >= limit) nxt_w = nxt - {1'b0, buf_size};
    else              nxt_w = nxt;
    step_addr = nxt_w[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_valid <= 1'b0;
      fetch_addr  <= '0;
    end else if (vsync) begin
      fetch_valid <= 1'b1;
      fetch_addr  <= start_q;
    end else if (fetch_valid && fetch_ready) begin
      fetch_addr  <= step_addr;
    end
  end
endmodule

// File: rtl/fbscan_addr_gen.sv
module fbscan_addr_gen #(
  parameter int AW = 32,
  parameter int FW = 12,
  parameter logic [AW-1:0] RST_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_arg,
  input  logic [AW-1:0] buf_size,
  input  logic          mem_vram,
  input  logic          vsync,
  input  logic [FW-1:0] v_total,
  input  logic [FW-1:0] v_sync,
  input  logic [FW-1:0] v_bstart,
  input  logic [FW-1:0] v_bend,
  output logic [AW-1:0] cur_start,
  output logic [AW-1:0] prev_start,
  output logic [AW-1:0] dma_init,
  output logic [AW-1:0] dma_start,
  output logic [AW-1:0] dma_end,
  output logic [FW-1:0] frame_size,
  output logic          fetch_valid,
  input  logic          fetch_ready,
  output logic [AW-1:0] fetch_addr
);
  logic          rdy_q;
  logic          cmd_fire;
  logic [AW-1:0] xfer_bytes, xfer_mask;
  logic [AW-1:0] base_q, start_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign cmd_ready  = rdy_q;
  assign cmd_fire   = cmd_valid && rdy_q;
  assign cur_start  = start_q;
  assign prev_start = prev_q;

  fbscan_xfer #(.AW(AW)) u_xfer (
    .buf_size(buf_size), .mem_vram(mem_vram),
    .xfer_bytes(xfer_bytes), .xfer_mask(xfer_mask)
  );

  fbscan_window #(.AW(AW), .RST_BASE(RST_BASE)) u_window (
    .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .buf_size(buf_size), .xfer_mask(xfer_mask),
    .base_q(base_q), .start_q(start_q), .prev_q(prev_q)
  );

  fbscan_shadow #(.AW(AW), .FW(FW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .start_q(start_q),
    .buf_size(buf_size), .xfer_bytes(xfer_bytes),
    .v_total(v_total), .v_sync(v_sync), .v_bstart(v_bstart), .v_bend(v_bend),
    .dma_init(dma_init), .dma_start(dma_start), .dma_end(dma_end),
    .frame_size(frame_size)
  );

  fbscan_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .start_q(start_q),
    .base_q(base_q), .buf_size(buf_size), .xfer_bytes(xfer_bytes),
    .fetch_ready(fetch_ready), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr)
  );
endmodule

// File: rtl/fbscan_addr_gen_chk.sv
module fbscan_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vsync,
  input logic          cmd_ready,
  input logic          fetch_valid,
  input logic          fetch_ready,
  input logic [AW-1:0] fetch_addr,
  input logic [AW-1:0] dma_init,
  input logic [AW-1:0] dma_start,
  input logic [AW-1:0] dma_end,
  input logic [AW-1:0] buf_size,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] start_q
);
  a_r2_start_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q >= base_q) && ({1'b0, start_q} < {1'b0, base_q} + {1'b0, buf_size}));

  a_r8_shadow_takes_start: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (dma_start == $past(start_q)) && (dma_init == dma_start));

  a_r9_shadow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(dma_init) && $stable(dma_start) && $stable(dma_end));

  a_r11_fetch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !vsync) |=> $stable(fetch_addr));

  a_r11_fetch_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready && !vsync) |=> (fetch_addr != $past(fetch_addr)));

  a_r11_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> fetch_valid);

  a_r12_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> cmd_ready);
endmodule

bind fbscan_addr_gen fbscan_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .vsync(vsync), .cmd_ready(cmd_ready),
  .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
  .fetch_addr(fetch_addr), .dma_init(dma_init), .dma_start(dma_start),
  .dma_end(dma_end), .buf_size(buf_size), .base_q(base_q), .start_q(start_q)
);

// File: tb/test_fbscan_addr_gen.sv
module test_fbscan_addr_gen;
  localparam int AW = 32;
  localparam int FW = 12;
  localparam longint M32 = 64'hFFFF_FFFF;
  localparam longint SZ = 65536;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'd0;
  logic [AW-1:0] cmd_arg = '0;
  logic [AW-1:0] buf_size = AW'(SZ);
  logic          mem_vram = 1'b0;
  logic          vsync = 1'b0;
  logic [FW-1:0] v_total = '0, v_sync = '0, v_bstart = '0, v_bend = '0;
  logic [AW-1:0] cur_start, prev_start, dma_init, dma_start, dma_end, fetch_addr;
  logic [FW-1:0] frame_size;
  logic          fetch_valid;
  logic          fetch_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  longint m_base, m_st, m_prev, m_init, m_dst, m_end, m_fs, m_fa;
  bit     m_fv;

  always #10 clk = ~clk;

  fbscan_addr_gen #(.AW(AW), .FW(FW), .RST_BASE('0)) i_fbscan_addr_gen (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .buf_size(buf_size),
    .mem_vram(mem_vram), .vsync(vsync), .v_total(v_total), .v_sync(v_sync),
    .v_bstart(v_bstart), .v_bend(v_bend), .cur_start(cur_start),
    .prev_start(prev_start), .dma_init(dma_init), .dma_start(dma_start),
    .dma_end(dma_end), .frame_size(frame_size), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_addr(fetch_addr)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint xfer_of(bit vram);
    return vram ? (SZ >> 10) : 64'd16;
  endfunction

  // Expected start after a scroll (R2, R3)
  function automatic longint exp_scroll(longint st, longint b, logic [31:0] arg, longint msk);
    longint off, s;
    off = longint'($signed(arg)) & ~msk;
    s = st + off;
    if (s >= b + SZ) s = s - SZ;
    else if (s < b) s = s + SZ;
    return s;
  endfunction

  function automatic longint exp_fetch_step(longint a, longint b, longint x);
    longint n;
    n = a + x;
    if (n >= b + SZ) n = n - SZ;
    return n;
  endfunction

  task automatic step(bit v, logic [1:0] op, logic [31:0] arg, bit vs, bit fr, string tag);
    longint x, msk, st0, b0;
    cmd_valid = v; cmd_op = op; cmd_arg = arg; vsync = vs; fetch_ready = fr;
    v_total = FW'($urandom_range(0, 255)); v_sync = FW'($urandom_range(0, 255));
    v_bstart = FW'($urandom_range(0, 255)); v_bend = FW'($urandom_range(0, 255));
    @(posedge clk);
    x = xfer_of(mem_vram); msk = x - 1; st0 = m_st; b0 = m_base;
    if (vs) begin
      m_init = st0; m_dst = st0; m_end = (st0 + SZ - x) & M32;
      m_fs = (longint'(v_total) + v_sync + v_bstart + v_bend - 1) & 64'hFFF;
      m_fv = 1; m_fa = st0;
    end else if (m_fv && fr) begin
      m_fa = exp_fetch_step(m_fa, b0, x);
    end
    if (v) begin
      case (op)
        2'd0: m_st = exp_scroll(st0, b0, arg, msk);
        2'd1: begin m_st = b0; m_prev = st0; end
        2'd2: m_st = longint'(arg) & ~msk & M32;
        default: begin
          m_base = longint'(arg) & ~msk & M32;
          m_st = (st0 - b0 + m_base) & M32;
        end
      endcase
    end
    @(negedge clk);
    chk(tag, cur_start, m_st);
    chk("R5", prev_start, m_prev);
    chk(vs ? "R8" : "R9", dma_init, m_init);
    chk(vs ? "R8" : "R9", dma_start, m_dst);
    chk("R4", dma_end, m_end);
    chk("R10", frame_size, m_fs);
    chk("R11", fetch_valid, m_fv);
    if (m_fv) chk("R11", fetch_addr, m_fa);
    chk("R12", cmd_ready, 1);
  endtask

  function automatic string tag_of(logic [1:0] op);
    case (op)
      2'd0: return "R2";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic random_run(int n);
    for (int i = 0; i < n; i++) begin
      logic [1:0] op;
      logic [31:0] arg;
      bit v;
      v = ($urandom_range(0, 1) == 1);
      op = 2'($urandom_range(0, 3));
      if (op == 2'd3 && $urandom_range(0, 7) != 0) op = 2'd0;
      case (op)
        2'd0: arg = 32'($urandom_range(0, 2 * 65536 - 2)) - 32'd65535;
        2'd2: arg = 32'(m_base + $urandom_range(0, 65535));
        2'd3: arg = $urandom & 32'h3FFF_FFFF;
        default: arg = $urandom;
      endcase
      step(v, op, arg, ($urandom_range(0, 15) == 0), ($urandom_range(0, 3) != 0),
           v ? tag_of(op) : "R12");
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_base = 0; m_st = 0; m_prev = 0; m_init = 0; m_dst = 0; m_end = 0;
    m_fs = 0; m_fa = 0; m_fv = 0;
    // R1: reset state
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1; vsync = 1'b1; fetch_ready = 1'b1;
    @(negedge clk);
    chk("R1", cur_start, 0); chk("R1", prev_start, 0);
    chk("R1", dma_init, 0); chk("R1", dma_start, 0); chk("R1", dma_end, 0);
    chk("R1", frame_size, 0); chk("R1", fetch_valid, 0); chk("R1", cmd_ready, 0);
    cmd_valid = 1'b0; vsync = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", cmd_ready, 1);

    // R7: rebase keeps displacement
    step(1, 2'd3, 32'h0010_0000, 0, 0, "R7");
    step(1, 2'd0, 32'h0000_0100, 0, 0, "R2");
    step(1, 2'd3, 32'h0020_0008, 0, 0, "R7");   // R3: low bits dropped
    // R8 R10 R11: first vsync
    step(0, 2'd0, 0, 1, 0, "R8");
    step(0, 2'd0, 0, 0, 0, "R11");
    // R11: wrap of fetch near top of window
    step(1, 2'd2, 32'(m_base + SZ - 32), 0, 0, "R6");
    step(0, 2'd0, 0, 1, 0, "R8");
    step(0, 2'd0, 0, 0, 1, "R11");
    step(0, 2'd0, 0, 0, 1, "R11");
    step(0, 2'd0, 0, 0, 1, "R11");
    // R2: wrap upward and downward
    step(1, 2'd0, 32'h0000_0040, 0, 0, "R2");
    step(1, 2'd1, 0, 0, 0, "R5");
    step(1, 2'd0, 32'hFFFF_FFD0, 0, 0, "R2");
    // R3: unaligned offsets round toward lower address
    step(1, 2'd0, 32'h0000_001F, 0, 0, "R3");
    step(1, 2'd0, 32'hFFFF_FFFF, 0, 0, "R3");
    // R5: home reports previous start
    step(1, 2'd1, 0, 0, 0, "R5");
    // R12: command and vsync in the same cycle; invalid command ignored
    step(1, 2'd0, 32'h0000_0200, 1, 0, "R12");
    step(0, 2'd0, 32'h0000_0400, 0, 0, "R12");
    random_run(3000);
    // R4: VRAM transfer sizing
    mem_vram = 1'b1;
    step(1, 2'd1, 0, 0, 0, "R5");
    step(0, 2'd0, 0, 1, 1, "R4");
    step(1, 2'd0, 32'h0000_007F, 0, 1, "R3");
    random_run(3000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule